// File: doc/BRIEF.md
# BCH syndrome expansion unit

This unit turns the partial remainders left behind by a page-read ECC engine into the complete syndrome set that a BCH error-locator solver needs. The code is binary BCH over GF(2^13). For a correction capability of t bits, the engine supplies t 16-bit remainders, packed two to a 32-bit word. The unit builds S1 through S2t from them and writes the results into an internal syndrome memory, which the solver reads through a plain address/data port.

Only the odd syndromes come from the remainders. For each set bit j of remainder i, the unit adds the field element alpha^((2i+1)·j) into the accumulator. It takes one remainder bit per clock. Each power is produced by multiplying the previous one in the field, so no log or antilog tables are stored. After that, each even syndrome is formed by squaring a lower syndrome that has already been computed, at one entry per clock.

A run is started by a single-cycle pulse together with the capability value. The remainder bank must stay stable while `busy` is high. Completion is reported by a one-cycle pulse. The interfaces are level based and have no back-pressure: the bank is sampled whenever the unit needs it, and the memory port can be read at any time.

Top module: `syn_expand`

## Requirements
- R1: After reset, `busy` and `done` are low and every syndrome address reads zero.
- R2: A `start` pulse is accepted only when the unit is idle and `cap` is 2, 4, 8, 12 or 24. Any other `cap` value leaves the unit idle and the stored syndromes unchanged.
- R3: While `busy` is high, `start` has no effect: neither the running job, its capability nor its timing changes.
- R4: Remainder i is `rem_words[16*i+15:16*i]`, which is the low half of 32-bit word i/2 when i is even and the high half when i is odd. Only bits 12:0 of each remainder take part, and bits 15:13 are ignored.
- R5: For i = 0..t-1, S(2i+1) is the XOR of alpha^(((2i+1)·j) mod 8191) over every set bit j (0..12) of remainder i. The field uses x^13+x^4+x^3+x+1, and alpha is the element x (value 2).
- R6: For j = 1..t, S(2j) equals S(j) squared in the field.
- R7: When S(j) is zero, S(2j) is zero.
- R8: Every accepted run first clears the whole memory, so after the run every address above 2t reads zero.
- R9: `busy` rises on the edge that accepts `start`. `done` is high for exactly one cycle, starting on the (14t+2)-th rising edge counting the accepting edge as the first, and `busy` is low from that same edge onward.
- R10: `rd_data` shows the entry at `rd_addr` without a clock delay. Address 0 and addresses above 2·MAX_T read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run request pulse |
| cap | input | 5 | Correction capability t |
| rem_words | input | 384 | Packed remainder bank, 12 words of 32 bits |
| rd_addr | input | 6 | Syndrome index to read |
| rd_data | output | 13 | Syndrome value at `rd_addr` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each odd syndrome comes from a long chain of successive field products, so a wrong power register or a wrong base step corrupts every later odd entry of the run. That damage becomes visible at the read port as soon as `done` rises. Because even entries square lower ones, an error in S1 also spreads into S2, S4, S8 and beyond, and this cascade makes single faults easy to see. Faults in the counters show up differently: they move the `done` edge away from 14t+2, or they leave stale values above 2t. For that reason the cycle of `done` is measured exactly in every run.

// File: rtl/syn_pkg.sv
package syn_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CLR, ST_ODD, ST_EVEN} syn_state_e;

  // capability values the unit will accept, bounded by the build size
  function automatic logic cap_supported(input int c, input int max_t);
    return ((c == 2) || (c == 4) || (c == 8) || (c == 12) || (c == 24)) && (c <= max_t);
  endfunction
endpackage

// File: rtl/syn_gf_mul.sv
module syn_gf_mul #(
  parameter int M = 13,
  parameter logic [M-1:0] POLY = 13'h001B
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] p
);
  // MSB-first shift-and-add with reduction after every shift
  always_comb begin
    logic [M-1:0] acc;
    acc = '0;
    for (int k = M - 1; k >= 0; k--) begin
      acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY : '0);
      if (b[k]) acc = acc ^ a;
    end
    p = acc;
  end
endmodule

// File: rtl/syn_store.sv
module syn_store #(
  parameter int M     = 13,
  parameter int DEPTH = 49,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [M-1:0]  wr_data,
  input  logic [AW-1:0] sq_addr,
  output logic [M-1:0]  sq_data,
  input  logic [AW-1:0] ext_addr,
  output logic [M-1:0]  ext_data
);
  logic [M-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else if (clr) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign sq_data  = (int'(sq_addr) < DEPTH) ? mem[sq_addr] : '0;
  assign ext_data = (int'(ext_addr) < DEPTH) ? mem[ext_addr] : '0;

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr != '0) && (int'(wr_addr) < DEPTH)); // R10
  AST_CLEAR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !wr_en); // R8
endmodule

// File: rtl/syn_seq.sv
module syn_seq
  import syn_pkg::*;
#(
  parameter int MAX_T = 24,
  parameter int M     = 13,
  parameter int RW    = 16,
  parameter int IW    = 5,
  parameter int AW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IW-1:0]     cap,
  input  logic [MAX_T*RW-1:0] rem_flat,
  output logic [M-1:0]      step_a,
  output logic [M-1:0]      step_b,
  input  logic [M-1:0]      step_p,
  output logic [M-1:0]      base_o,
  input  logic [M-1:0]      base_nx,
  output logic [AW-1:0]     sq_addr,
  input  logic [M-1:0]      sq_data,
  output logic              clr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [M-1:0]      wr_data,
  output logic              busy,
  output logic              done
);
  localparam int BW = $clog2(M);
  localparam logic [BW-1:0] LAST_BIT = BW'(M - 1);

  syn_state_e    state_q;
  logic [IW-1:0] cap_q;
  logic [IW-1:0] idx_q;
  logic [BW-1:0] bit_q;
  logic [M-1:0]  acc_q, pw_q, base_q, acc_nx;
  logic [M-1:0]  rem_cur;
  logic          done_q;
  logic          cap_ok;

  assign cap_ok  = cap_supported(int'(cap), MAX_T);
  assign rem_cur = rem_flat[int'(idx_q)*RW +: M];
  assign acc_nx  = acc_q ^ (rem_cur[bit_q] ? pw_q : '0);

  assign step_a  = (state_q == ST_ODD) ? pw_q   : sq_data;
  assign step_b  = (state_q == ST_ODD) ? base_q : sq_data;
  assign base_o  = base_q;
  assign sq_addr = {1'b0, idx_q};

  always_comb begin
    clr     = (state_q == ST_CLR);
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    if (state_q == ST_ODD) begin
      wr_en   = (bit_q == LAST_BIT);
      wr_addr = {idx_q, 1'b1};
      wr_data = acc_nx;
    end else if (state_q == ST_EVEN) begin
      wr_en   = 1'b1;
      wr_addr = {idx_q, 1'b0};
      wr_data = step_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cap_q   <= '0;
      idx_q   <= '0;
      bit_q   <= '0;
      acc_q   <= '0;
      pw_q    <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start && cap_ok) begin
            cap_q   <= cap;
            state_q <= ST_CLR;
          end
        end
        ST_CLR: begin
          idx_q   <= '0;
          bit_q   <= '0;
          acc_q   <= '0;
          pw_q    <= M'(1);
          base_q  <= M'(2);
          state_q <= ST_ODD;
        end
        ST_ODD: begin
          if (bit_q == LAST_BIT) begin
            bit_q  <= '0;
            acc_q  <= '0;
            pw_q   <= M'(1);
            base_q <= base_nx;
            if (idx_q == cap_q - 1'b1) begin
              idx_q   <= IW'(1);
              state_q <= ST_EVEN;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
            acc_q <= acc_nx;
            pw_q  <= step_p;
          end
        end
        ST_EVEN: begin
          if (idx_q == cap_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state_q == ST_EVEN)); // R9
  AST_BUSY_KEEPS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cap_q)); // R3
  AST_BAD_CAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !cap_ok) |=> !busy); // R2
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ODD) |-> (bit_q <= LAST_BIT)); // R5
  AST_ZERO_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_EVEN) && (sq_data == '0)) |-> (wr_data == '0)); // R7
endmodule

// File: rtl/syn_expand.sv
module syn_expand #(
  parameter int MAX_T = 24,
  parameter int M     = 13,
  parameter int RW    = 16,
  parameter logic [M-1:0] POLY = 13'h001B
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [$clog2(MAX_T+1)-1:0]    cap,
  input  logic [MAX_T*RW-1:0]           rem_words,
  input  logic [$clog2(MAX_T+1):0]      rd_addr,
  output logic [M-1:0]                  rd_data,
  output logic                          busy,
  output logic                          done
);
  localparam int IW    = $clog2(MAX_T + 1);
  localparam int AW    = IW + 1;
  localparam int DEPTH = 2 * MAX_T + 1;

  logic [M-1:0]  step_a, step_b, step_p, base_q, base_nx, sq_data, wr_data;
  logic [AW-1:0] sq_addr, wr_addr;
  logic          clr, wr_en;

  syn_seq #(.MAX_T(MAX_T), .M(M), .RW(RW), .IW(IW), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cap(cap), .rem_flat(rem_words),
    .step_a(step_a), .step_b(step_b), .step_p(step_p),
    .base_o(base_q), .base_nx(base_nx),
    .sq_addr(sq_addr), .sq_data(sq_data),
    .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  // shared product: power chain in odd phase, squaring in even phase
  syn_gf_mul #(.M(M), .POLY(POLY)) u_mul_step (
    .a(step_a), .b(step_b), .p(step_p)
  );

  // advance the odd-phase base by alpha^2
  syn_gf_mul #(.M(M), .POLY(POLY)) u_mul_base (
    .a(base_q), .b(M'(4)), .p(base_nx)
  );

  syn_store #(.M(M), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sq_addr(sq_addr), .sq_data(sq_data),
    .ext_addr(rd_addr), .ext_data(rd_data)
  );
endmodule

// File: tb/test_syn_expand.sv
module test_syn_expand;
  localparam int MT = 24;
  localparam int NS = 2 * MT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [4:0]    cap = '0;
  logic [MT*16-1:0] rem_words = '0;
  logic [5:0]    rd_addr = '0;
  logic [12:0]   rd_data;
  logic          busy, done;

  int nchk = 0;
  int nerr = 0;
  logic [12:0] expq[$];
  logic [12:0] last_s [0:NS];
  int  run_cap = 0;
  string run_note = "";
  logic go_flag = 1'b0;

  always #2.5 clk = ~clk;

  syn_expand i_syn_expand (
    .clk(clk), .rst_n(rst_n), .start(start), .cap(cap), .rem_words(rem_words),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference field arithmetic, log/exp based
  function automatic logic [12:0] xstep(input logic [12:0] v);
    return {v[11:0], 1'b0} ^ (v[12] ? 13'h001B : 13'h0000);
  endfunction

  function automatic logic [12:0] apow(input int e);
    logic [12:0] v = 13'd1;
    for (int n = 0; n < e % 8191; n++) v = xstep(v);
    return v;
  endfunction

  function automatic logic [12:0] fsq(input logic [12:0] s);
    logic [12:0] v = 13'd1;
    int e = 0;
    if (s == 0) return 13'd0;
    for (int n = 0; n < 8191; n++) begin
      if (v == s) begin e = n; break; end
      v = xstep(v);
    end
    return apow((2 * e) % 8191);
  endfunction

  task automatic build_expect(input int t, input logic [MT*16-1:0] r);
    logic [12:0] s [0:NS];
    for (int k = 0; k <= NS; k++) s[k] = '0;
    for (int i = 0; i < t; i++) begin
      logic [15:0] rr = r[16*i +: 16];
      for (int j = 0; j < 13; j++)
        if (rr[j]) s[2*i+1] = s[2*i+1] ^ apow((2*i+1) * j);
    end
    for (int j = 1; j <= t; j++) s[2*j] = fsq(s[j]);
    for (int k = 1; k <= NS; k++) begin
      expq.push_back(s[k]);
      last_s[k] = s[k];
    end
  endtask

  // monitor: read the memory after done and compare against the queue
  initial begin
    forever begin
      wait (go_flag);
      for (int k = 1; k <= NS; k++) begin
        logic [12:0] e;
        string tg;
        @(negedge clk);
        rd_addr = 6'(k);
        #1;
        e = expq.pop_front();
        if (k > 2 * run_cap) tg = "R8";
        else if (k % 2 == 1) tg = "R5";
        else if (e == 0) tg = "R7";
        else tg = "R6";
        chk($sformatf("%s %s S%0d", run_note, tg, k), 32'(rd_data), 32'(e));
      end
      go_flag = 1'b0;
    end
  end

  task automatic run(input int t, input logic [MT*16-1:0] r, input string note, input bit inject);
    int cnt = 0;
    bit got = 0;
    build_expect(t, r);
    run_cap = t;
    run_note = note;
    @(negedge clk);
    cap = 5'(t);
    rem_words = r;
    start = 1'b1;
    while (!got && cnt < 2000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (cnt == 1) chk({note, " R9 busy rises"}, 32'(busy), 32'd1);
      if (inject && (cnt == 10 || cnt == 40)) begin
        start = 1'b1;
        cap = 5'd24;  // R3 must not change the running job
      end else begin
        start = 1'b0;
        cap = 5'(t);
      end
      if (done) got = 1;
    end
    chk({note, " R9 done latency"}, 32'(cnt), 32'(14 * t + 2));
    chk({note, " R9 busy low at done"}, 32'(busy), 32'd0);
    @(negedge clk);
    chk({note, " R9 done one cycle"}, 32'(done), 32'd0);
    go_flag = 1'b1;
    wait (!go_flag);
  endtask

  function automatic logic [MT*16-1:0] pattern(input int seed);
    logic [MT*16-1:0] r = '0;
    for (int i = 0; i < MT; i++) r[16*i +: 16] = 16'((i + 1) * 40503 + seed * 7919);
    return r;
  endfunction

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=%0d expected<150000", wd);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
      end
    end
  end

  initial begin
    logic [MT*16-1:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    for (int k = 0; k <= NS; k += 7) begin
      rd_addr = 6'(k);
      #1;
      chk($sformatf("R1 S%0d", k), 32'(rd_data), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    r = '0;
    r[0] = 1'b1;
    r[16 + 5] = 1'b1;
    run(2, r, "single-bit", 0);
    run(4, pattern(1), "t4", 0);
    run(8, pattern(2), "t8", 0);
    run(12, pattern(3), "t12", 0);
    // R4: upper three bits of each remainder set, must not contribute
    r = '0;
    for (int i = 0; i < MT; i++) r[16*i +: 16] = 16'hE000 | 16'(i * 301 + 5);
    run(24, r, "R4 high-bits", 0);
    run(24, '0, "zero-rem", 0);
    r = pattern(4);
    r[16 +: 16] = 16'hE000;   // S3 zero, so S6 and S12 zero (R7)
    r[16*2 +: 16] = 16'h0000; // S5 zero
    run(8, r, "zero-odd", 0);
    run(2, pattern(5), "shrink", 0);

    // R2: unsupported capability leaves idle and memory intact
    @(negedge clk);
    cap = 5'd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 20; n++) begin
      chk("R2 busy stays low", 32'(busy | done), 0);
      @(negedge clk);
    end
    rd_addr = 6'd1;
    #1;
    chk("R2 S1 unchanged", 32'(rd_data), 32'(last_s[1]));
    rd_addr = 6'd4;
    #1;
    chk("R2 S4 unchanged", 32'(rd_data), 32'(last_s[4]));

    run(4, pattern(6), "R3 inject", 1);

    // R10 out-of-range addresses
    rd_addr = 6'd0;
    #1;
    chk("R10 addr0", 32'(rd_data), 0);
    rd_addr = 6'd63;
    #1;
    chk("R10 addr63", 32'(rd_data), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule